// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 interrupt inputs onto one processor interrupt line. Each input has a mode register and a vector register. The mode register holds a 3-bit priority, an edge-or-level select and a polarity invert. The vector register holds the value handed to the processor. A simple synchronous register bus configures the block and services it.

When the processor reads the vector port, it receives the vector of the best pending, enabled input, and that read also acknowledges the interrupt. The read pushes the winner's priority and number onto an eight-entry nesting stack. If the winner is edge sensitive, the read also clears its latched request. The interrupt line is raised again only for a request whose priority is strictly above the one now being served, so higher-priority work preempts lower-priority work. Each write to the end-of-interrupt port closes the innermost service level. When nothing qualifies, the vector read returns a programmable spurious value and leaves the stack unchanged.

Inputs are taken as synchronous to `clk`. All bus accesses complete in one cycle. Read data is valid from the clock edge that accepts the read until the next read.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the following all read zero and `irq_out` is low: the enable mask (0x110), the pending word (0x10C), the status (0x108), the line register (0x114) and the spurious register. Nothing is pending while all inputs are low.
- R2: Each source n has a mode register at byte address 4n and a vector register at 0x80+4n. The mode register holds priority in bits [2:0], edge select in bit 5 and invert in bit 6. The spurious value is held at 0x134. All of these read back as written.
- R3: Each 1 bit written to 0x120 enables that source, and each 1 bit written to 0x124 disables it. Zero bits leave the mask unchanged. The mask reads at 0x110.
- R4: Each 1 bit written to 0x12C marks that source pending, and each 1 bit written to 0x128 removes that software or latched request. The pending word reads at 0x10C, bit n for source n.
- R5: A read of 0x100 returns the vector of the pending, enabled source with the highest priority (7 highest). Ties go to the lower source number. After that read, 0x108 returns that source's number.
- R6: One cycle after the state changes, `irq_out` is high exactly when some pending, enabled source has a priority above the top of the nesting stack, or when such a source exists and the stack is empty. 0x114 reads the line in bit 0.
- R7: Any write to 0x130 pops one nesting level, and 0x108 then returns the source that was interrupted. The stack holds at most eight levels, and eight such writes always empty it.
- R8: A read of 0x100 while nothing qualifies under R6 returns the spurious value and pushes nothing.
- R9: An edge source latches a request on its active transition, and its acknowledging vector read clears that request. A level source is pending for as long as its input is active, and acknowledging it does not clear it.
- R10: The invert bit makes a level source active low and an edge source fall-sensitive.
- R11: A pending source that is disabled neither raises `irq_out` nor wins a vector read, but it still shows in the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the accepting edge |
| src_in | input | 32 | Interrupt inputs, one per source |
| irq_out | output | 1 | Processor interrupt line |

## Verification
A write or an input change takes effect at the clock edge that accepts it, and `irq_out` follows one edge later. Read data is captured at the edge that accepts the read, and a vector read's push and request clear also happen at that edge. The bench drives every access on a falling edge and samples read data on the next falling edge. Before it samples the line, it waits one further falling edge after any write, acknowledge or input change. The sweep rebuilds the expected winner, vector and line level arithmetically from the pattern it applied.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_NSRC   = 32;
  localparam int unsigned VIC_PRIO_W = 3;
  localparam int unsigned VIC_DEPTH  = 8;
  localparam int unsigned VIC_AW     = 12;
  localparam int unsigned VIC_DW     = 32;

  // control/status byte addresses
  localparam logic [11:0] A_VEC_RD = 12'h100;
  localparam logic [11:0] A_STATUS = 12'h108;
  localparam logic [11:0] A_PEND   = 12'h10C;
  localparam logic [11:0] A_MASK   = 12'h110;
  localparam logic [11:0] A_LINE   = 12'h114;
  localparam logic [11:0] A_EN     = 12'h120;
  localparam logic [11:0] A_DIS    = 12'h124;
  localparam logic [11:0] A_CLR    = 12'h128;
  localparam logic [11:0] A_SET    = 12'h12C;
  localparam logic [11:0] A_EOI    = 12'h130;
  localparam logic [11:0] A_SPUR   = 12'h134;

  // mode register field positions
  localparam int unsigned MODE_EDGE_BIT = 5;
  localparam int unsigned MODE_INV_BIT  = 6;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_sel,
  input  logic [NSRC-1:0] inv_sel,
  input  logic [NSRC-1:0] set_cmd,
  input  logic [NSRC-1:0] clr_cmd,
  input  logic [NSRC-1:0] ack_hit,
  output logic [NSRC-1:0] pending
);
  logic [NSRC-1:0] src_prev;

  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_in;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic act_now;
    logic act_was;
    logic req_q;
    logic rise;
    assign act_now = src_in[g] ^ inv_sel[g];
    assign act_was = src_prev[g] ^ inv_sel[g];
    assign rise    = edge_sel[g] & act_now & ~act_was;

    always_ff @(posedge clk) begin
      if (rst) req_q <= 1'b0;
      else     req_q <= (req_q & ~clr_cmd[g] & ~(ack_hit[g] & edge_sel[g]))
                        | set_cmd[g] | rise;
    end

    assign pending[g] = req_q | (~edge_sel[g] & act_now);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   cand,
  input  logic [PRIO_W-1:0] prio [NSRC],
  output logic              found,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRIO_W-1:0] win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [IDX_W-1:0]  push_idx,
  output logic              empty,
  output logic              full,
  output logic [PRIO_W-1:0] top_prio,
  output logic [IDX_W-1:0]  top_idx,
  output logic [CNT_W-1:0]  depth
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned ENT_W = PRIO_W + IDX_W;

  logic [ENT_W-1:0] ent [DEPTH];
  logic [ENT_W-1:0] top_ent;

  assign empty = (depth == '0);
  assign full  = (depth == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full) ent[depth[PTR_W-1:0]] <= {push_prio, push_idx};
  end

  always_ff @(posedge clk) begin
    if (rst)                  depth <= '0;
    else if (push && !full)   depth <= depth + 1'b1;
    else if (pop && !empty)   depth <= depth - 1'b1;
  end

  assign top_ent  = empty ? '0 : ent[PTR_W'(depth - 1'b1)];
  assign top_prio = top_ent[ENT_W-1:IDX_W];
  assign top_idx  = top_ent[IDX_W-1:0];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NSRC   = VIC_NSRC,
  parameter int unsigned PRIO_W = VIC_PRIO_W,
  parameter int unsigned DEPTH  = VIC_DEPTH,
  parameter int unsigned AW     = VIC_AW,
  parameter int unsigned DW     = VIC_DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int unsigned IDX_W    = $clog2(NSRC);
  localparam int unsigned BANK_LSB = 2 + IDX_W;
  localparam int unsigned BANK_W   = AW - BANK_LSB;
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);

  // bus decode
  logic             wr, rd;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0] sel_idx;
  logic             in_mode, in_vec;
  logic             is_vrd, is_eoi;

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign bank    = bus_addr[AW-1:BANK_LSB];
  assign sel_idx = bus_addr[BANK_LSB-1:2];
  assign in_mode = (bank == BANK_W'(0)) && (bus_addr[1:0] == 2'b00);
  assign in_vec  = (bank == BANK_W'(1)) && (bus_addr[1:0] == 2'b00);
  assign is_vrd  = rd && (bus_addr == AW'(A_VEC_RD));
  assign is_eoi  = wr && (bus_addr == AW'(A_EOI));

  // configuration state
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   edge_q, inv_q, mask_q;
  logic [DW-1:0]     spur_q;
  logic [DW-1:0]     vec_mem [NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      edge_q <= '0;
      inv_q  <= '0;
    end else if (wr && in_mode) begin
      prio_q[sel_idx] <= bus_wdata[PRIO_W-1:0];
      edge_q[sel_idx] <= bus_wdata[MODE_EDGE_BIT];
      inv_q[sel_idx]  <= bus_wdata[MODE_INV_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (wr && in_vec) vec_mem[sel_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      spur_q <= '0;
    end else if (wr) begin
      if (bus_addr == AW'(A_EN))   mask_q <= mask_q | bus_wdata[NSRC-1:0];
      if (bus_addr == AW'(A_DIS))  mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
      if (bus_addr == AW'(A_SPUR)) spur_q <= bus_wdata;
    end
  end

  // sources and pending
  logic [NSRC-1:0] set_cmd, clr_cmd, ack_hit, pend;

  assign set_cmd = (wr && bus_addr == AW'(A_SET)) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_cmd = (wr && bus_addr == AW'(A_CLR)) ? bus_wdata[NSRC-1:0] : '0;

  vic_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .src_in(src_in), .edge_sel(edge_q), .inv_sel(inv_q),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd), .ack_hit(ack_hit), .pending(pend)
  );

  // arbitration
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand(pend & mask_q), .prio(prio_q),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  // nesting
  logic              stk_empty, stk_full;
  logic [PRIO_W-1:0] top_prio;
  logic [IDX_W-1:0]  top_idx;
  logic [CNT_W-1:0]  depth;
  logic              eligible, ack;

  assign eligible = found && !stk_full && (stk_empty || win_prio > top_prio);
  assign ack      = is_vrd && eligible;

  always_comb begin
    ack_hit = '0;
    if (ack) ack_hit[win_idx] = 1'b1;
  end

  vic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stack (
    .clk(clk), .rst(rst), .push(ack), .pop(is_eoi),
    .push_prio(win_prio), .push_idx(win_idx),
    .empty(stk_empty), .full(stk_full),
    .top_prio(top_prio), .top_idx(top_idx), .depth(depth)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= eligible;
  end

  // read path
  logic [DW-1:0]    reg_rd, rdata_q, mem_rd_q;
  logic             use_mem, rsel_mem_q;
  logic [IDX_W-1:0] rd_idx;

  assign use_mem = in_vec || (is_vrd && eligible);
  assign rd_idx  = is_vrd ? win_idx : sel_idx;

  always_comb begin
    reg_rd = '0;
    if (in_mode) begin
      reg_rd[PRIO_W-1:0]    = prio_q[sel_idx];
      reg_rd[MODE_EDGE_BIT] = edge_q[sel_idx];
      reg_rd[MODE_INV_BIT]  = inv_q[sel_idx];
    end else begin
      case (bus_addr)
        AW'(A_VEC_RD): reg_rd = spur_q;
        AW'(A_STATUS): reg_rd[IDX_W-1:0] = stk_empty ? '0 : top_idx;
        AW'(A_PEND):   reg_rd[NSRC-1:0] = pend;
        AW'(A_MASK):   reg_rd[NSRC-1:0] = mask_q;
        AW'(A_LINE):   reg_rd[0] = irq_out;
        AW'(A_SPUR):   reg_rd = spur_q;
        default:       reg_rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      rsel_mem_q <= 1'b0;
    end else if (rd) begin
      rdata_q    <= reg_rd;
      rsel_mem_q <= use_mem;
    end
  end

  always_ff @(posedge clk) begin
    if (rd && use_mem) mem_rd_q <= vec_mem[rd_idx];
  end

  assign bus_rdata = rsel_mem_q ? mem_rd_q : rdata_q;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            irq_out,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] pend,
  input logic [CNT_W-1:0] depth
);
  // R1: leaving reset, line low, stack empty, mask clear
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && depth == '0 && mask == '0));

  // R3: enable bits are set in the mask after the write
  p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == AW'(A_EN))
      |=> ((mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  // R3: disable bits are cleared in the mask after the write
  p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == AW'(A_DIS))
      |=> ((mask & $past(bus_wdata[NSRC-1:0])) == '0));

  // R6/R11: the line is only raised for an enabled pending source
  p_line_needs_cand_r6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(pend & mask)));

  // R7: nesting never exceeds its depth
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  // R7: end-of-interrupt pops exactly one level
  p_eoi_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == AW'(A_EOI) && depth != '0)
      |=> (depth == $past(depth) - 1'b1));
endmodule

bind vec_irq_ctrl vic_ctrl_chk #(
  .NSRC(NSRC), .DEPTH(DEPTH), .AW(AW), .DW(DW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .mask(mask_q), .pend(pend), .depth(depth)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_out;

  localparam logic [31:0] SPUR = 32'h5A5A_0001;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  function automatic logic [31:0] vexp(input int n);
    return 32'hC000_0000 | (n << 8) | (n ^ 5);
  endfunction
  function automatic logic [2:0] pr(input int n);
    return 3'((n * 3 + 1) % 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] x;
    logic [31:0] msk;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(12'h110, d); chk("R1 mask", d, 0);
    rd(12'h10C, d); chk("R1 pending", d, 0);
    rd(12'h108, d); chk("R1 status", d, 0);
    rd(12'h114, d); chk("R1 line reg", d, 0);
    rd(12'h134, d); chk("R1 spurious", d, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);

    // R2 register readback
    wr(12'h134, SPUR);
    for (int n = 0; n < 32; n++) begin
      wr(12'(12'h080 + 4 * n), vexp(n));
      wr(12'(4 * n), {29'b0, pr(n)});
    end
    for (int n = 0; n < 32; n++) begin
      rd(12'(12'h080 + 4 * n), d); chk("R2 vector", d, vexp(n));
      rd(12'(4 * n), d);           chk("R2 mode", d, {29'b0, pr(n)});
    end
    rd(12'h134, d); chk("R2 spurious", d, SPUR);
    wr(12'h01C, 32'h0000_0065);
    rd(12'h01C, d); chk("R2 mode edge/inv", d, 32'h0000_0065);
    wr(12'h01C, {29'b0, pr(7)});

    // R3 mask commands
    wr(12'h120, 32'hF0F0_1234); rd(12'h110, d); chk("R3 enable", d, 32'hF0F0_1234);
    wr(12'h124, 32'h0000_1200); rd(12'h110, d); chk("R3 disable", d, 32'hF0F0_0034);
    wr(12'h120, 32'h0000_0001); rd(12'h110, d); chk("R3 enable keep", d, 32'hF0F0_0035);
    wr(12'h124, 32'hFFFF_FFFF); rd(12'h110, d); chk("R3 disable all", d, 0);

    // R4/R5/R6/R8 sweep with arithmetic winner
    x = 32'h1234_5678;
    for (int k = 0; k < 48; k++) begin
      logic [31:0] pat;
      int best; int bp;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      pat = (k == 0) ? 32'h0101_0101 : x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      msk = (k == 1) ? 32'h0 : (x | 32'h0100_0100);
      best = -1; bp = -1;
      for (int n = 0; n < 32; n++)
        if (pat[n] && msk[n] && int'(pr(n)) > bp) begin best = n; bp = int'(pr(n)); end
      wr(12'h12C, pat);
      wr(12'h120, msk);
      rd(12'h10C, d); chk("R4 set pending", d, pat);
      rd(12'h114, d); chk("R6 line reg", d, {31'b0, best >= 0});
      chk("R6 irq_out", {31'b0, irq_out}, {31'b0, best >= 0});
      rd(12'h100, d);
      if (best >= 0) chk("R5 winner vector", d, vexp(best));
      else           chk("R8 spurious vector", d, SPUR);
      rd(12'h108, d); chk("R5 status", d, (best >= 0) ? best : 0);
      wr(12'h128, 32'hFFFF_FFFF);
      rd(12'h10C, d); chk("R4 clear pending", d, 0);
      wr(12'h124, 32'hFFFF_FFFF);
      wr(12'h130, 0);
      rd(12'h108, d); chk("R7 status after pop", d, 0);
    end

    // R7/R6/R8 nesting, edge sources via software set
    wr(12'h004, 32'h22); wr(12'h008, 32'h22); wr(12'h00C, 32'h25);
    wr(12'h120, 32'h0000_000E);
    wr(12'h12C, 32'h2); settle();
    chk("R6 irq first", {31'b0, irq_out}, 1);
    rd(12'h100, d); chk("R5 vec src1", d, vexp(1)); settle();
    chk("R9 edge ack clears", {31'b0, irq_out}, 0);
    wr(12'h12C, 32'h4); settle();
    chk("R6 equal prio no irq", {31'b0, irq_out}, 0);
    rd(12'h100, d); chk("R8 spurious when equal", d, SPUR);
    wr(12'h12C, 32'h8); settle();
    chk("R6 preempt irq", {31'b0, irq_out}, 1);
    rd(12'h100, d); chk("R5 vec src3", d, vexp(3));
    rd(12'h108, d); chk("R5 status src3", d, 3);
    wr(12'h130, 0);
    rd(12'h108, d); chk("R7 status back to src1", d, 1);
    chk("R6 irq held off", {31'b0, irq_out}, 0);
    wr(12'h130, 0); settle();
    rd(12'h108, d); chk("R7 status empty", d, 0);
    chk("R6 irq after unwind", {31'b0, irq_out}, 1);
    rd(12'h100, d); chk("R5 vec src2", d, vexp(2));
    wr(12'h130, 0);
    wr(12'h124, 32'hFFFF_FFFF);

    // R7 eight-deep nesting
    for (int i = 0; i < 8; i++) wr(12'(4 * (8 + i)), 32'h20 | i);
    wr(12'h120, 32'h0000_FF00);
    for (int i = 0; i < 8; i++) begin
      wr(12'h12C, 32'h1 << (8 + i)); settle();
      chk("R6 nest irq", {31'b0, irq_out}, 1);
      rd(12'h100, d); chk("R7 nest vector", d, vexp(8 + i));
    end
    settle();
    chk("R7 full no irq", {31'b0, irq_out}, 0);
    rd(12'h108, d); chk("R7 full status", d, 15);
    for (int j = 0; j < 8; j++) begin
      wr(12'h130, 0);
      rd(12'h108, d); chk("R7 unwind status", d, (j < 7) ? (14 - j) : 0);
    end
    chk("R7 released", {31'b0, irq_out}, 0);
    wr(12'h124, 32'hFFFF_FFFF);

    // R9 edge and level inputs
    wr(12'h050, 32'h24); wr(12'h054, 32'h03);
    wr(12'h120, 32'h0030_0000);
    @(negedge clk); src_in[20] = 1; settle();
    rd(12'h10C, d); chk("R9 edge latched", d, 32'h0010_0000);
    chk("R9 edge irq", {31'b0, irq_out}, 1);
    rd(12'h100, d); chk("R9 edge vector", d, vexp(20));
    wr(12'h130, 0);
    rd(12'h10C, d); chk("R9 edge cleared while high", d, 0);
    @(negedge clk); src_in[20] = 0;
    @(negedge clk); src_in[21] = 1; settle();
    rd(12'h100, d); chk("R9 level vector", d, vexp(21));
    wr(12'h130, 0);
    rd(12'h10C, d); chk("R9 level stays pending", d, 32'h0020_0000);
    @(negedge clk); src_in[21] = 0;
    rd(12'h10C, d); chk("R9 level drops", d, 0);
    wr(12'h124, 32'hFFFF_FFFF);

    // R10 inverted polarity
    wr(12'h058, 32'h41); wr(12'h05C, 32'h61);
    rd(12'h10C, d); chk("R10 active-low level", d, 32'h0040_0000);
    @(negedge clk); src_in[22] = 1; src_in[23] = 1; settle();
    rd(12'h10C, d); chk("R10 high inactive, no rise edge", d, 0);
    @(negedge clk); src_in[22] = 0; src_in[23] = 0; settle();
    rd(12'h10C, d); chk("R10 falling edge latched", d, 32'h00C0_0000);
    wr(12'h128, 32'h0080_0000);

    // R11 disabled pending source ignored
    settle();
    chk("R11 no irq", {31'b0, irq_out}, 0);
    rd(12'h100, d); chk("R11 spurious", d, SPUR);
    rd(12'h108, d); chk("R11 nothing pushed", d, 0);
    rd(12'h10C, d); chk("R11 still pending", d, 32'h0040_0000);
    wr(12'h058, 32'h01);

    done = 1;
    summary();
    $finish;
  end
endmodule